// File: doc/BRIEF.md
# Dual-Channel Serial Controller Register Decoder

This block sits between a CPU bus and a two-channel serial controller. Each bus access presents a 4-bit register address, a direction flag and a strobe. The decoder turns the access into a one-hot write enable for the target register, a read-data select code for the external read multiplexer, or a single-clock action pulse. The same address can select one register on a read and a different one on a write.

Each channel keeps a sticky mode pointer. The first mode-register access after reset, or after a pointer-reset command, reaches the first mode register. That access moves the pointer to the second mode register, and it stays there.

Some addresses hold no data. Reads of two of them start and stop the counter/timer. Writes to the same two set and clear output port bits. A read of a receive holding register sends a one-clock pop to that channel's receive FIFO.

Top module: `regdec_top`

## Requirements
- R1: While rst_ni is low, and after it is released, every output is zero and both mode pointers select the first mode register.
- R2: An access is taken on the first rising clock edge at which sel_i is high after being low. Its outputs are high for exactly the one following clock. A strobe held for several clocks produces no further pulses.
- R3: A mode access is an access to local offset 0 of a channel (0x0 for A, 0x8 for B). While the pointer is at the first mode register, a mode access targets that register and moves the pointer to the second. Later mode accesses target the second register until the pointer is reset.
- R4: A write to a channel's command register (0x2 for A, 0xA for B) with wdata_i[6:4] = 3'b001 returns that channel's pointer to the first mode register. The other channel's pointer is not changed.
- R5: Channel-local split addresses: offset 1 reads status (rd_sel 3/11) and writes clock select (we bit 2/11). Offset 3 reads receive holding (rd_sel 4/12) and writes transmit holding (we bit 4/13). Channel B is offset by 0x8.
- R6: Writes to 0x2 and 0xA assert we bit 3 and we bit 12 respectively. Reads of 0x2 and 0xA produce no output and leave both pointers unchanged.
- R7: A read of 0xE pulses ctr_start_o and a read of 0xF pulses ctr_stop_o. A write of 0xE pulses opb_set_o and a write of 0xF pulses opb_clr_o. No more than one of these four is high in any cycle.
- R8: Shared addresses:
  - 0x4 reads rd_sel 5 and writes we bit 5.
  - 0x5 reads rd_sel 6 and writes we bit 6.
  - 0x6 reads rd_sel 7 and writes we bit 7.
  - 0x7 reads rd_sel 8 and writes we bit 8.
  - 0xC reads rd_sel 13 and writes we bit 14.
  - 0xD reads rd_sel 14 and writes we bit 15.
- R9: A read of 0x3 pulses rx_pop_o[0] and a read of 0xB pulses rx_pop_o[1]. No other access pops.
- R10: Encodings and exclusivity:
  - Mode write enables are bit 0/1 for A (first/second register) and bit 9/10 for B.
  - Mode read codes are 1/2 for A and 9/10 for B.
  - rd_sel_o is 0 whenever no read is decoded.
  - A write never sets rd_sel_o, and a read never sets a we_o bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Bus access strobe |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 4 | Register address |
| wdata_i | input | 8 | Write data (command field decoded) |
| we_o | output | 16 | One-hot register write enables |
| rd_sel_o | output | 4 | Read multiplexer select code |
| ctr_start_o | output | 1 | Counter start pulse |
| ctr_stop_o | output | 1 | Counter stop pulse |
| opb_set_o | output | 1 | Output-port set pulse |
| opb_clr_o | output | 1 | Output-port clear pulse |
| rx_pop_o | output | 2 | Receive FIFO pop per channel |

## Verification
Two things happen on the same edge for a mode access: the decode picks its target using the pointer value, and the pointer advances. The decode must use the pre-advance value. The bench provokes this with back-to-back mode accesses separated by the minimum one-clock strobe gap. The first access must land on the first mode register and the next on the second. The bench also interleaves pointer-reset commands on one channel with mode accesses on the other. Every pulse is judged against a bench model that tracks both pointers independently.

// File: rtl/regdec_pkg.sv
package regdec_pkg;
  localparam int NUM_CH  = 2;
  localparam int ADDR_W  = 4;
  localparam int NUM_WE  = 16;
  localparam int RSEL_W  = 4;
  // per-channel write-enable and read-select bases
  localparam int WE_CH_STRIDE = 9;
  localparam int RS_CH_STRIDE = 8;

  typedef enum logic [RSEL_W-1:0] {
    RS_NONE  = 4'd0,
    RS_MR1A  = 4'd1,
    RS_MR2A  = 4'd2,
    RS_SRA   = 4'd3,
    RS_RHRA  = 4'd4,
    RS_ICHG  = 4'd5,
    RS_ISTAT = 4'd6,
    RS_CTHI  = 4'd7,
    RS_CTLO  = 4'd8,
    RS_MR1B  = 4'd9,
    RS_MR2B  = 4'd10,
    RS_SRB   = 4'd11,
    RS_RHRB  = 4'd12,
    RS_IVEC  = 4'd13,
    RS_IPORT = 4'd14
  } rsel_e;

  // we_o bit positions (channel A; channel B adds WE_CH_STRIDE)
  localparam int WE_MR1   = 0;
  localparam int WE_MR2   = 1;
  localparam int WE_CSEL  = 2;
  localparam int WE_CMD   = 3;
  localparam int WE_THR   = 4;
  localparam int WE_AUX   = 5;
  localparam int WE_IMSK  = 6;
  localparam int WE_CTHI  = 7;
  localparam int WE_CTLO  = 8;
  localparam int WE_IVEC  = 14;
  localparam int WE_OPCFG = 15;

  typedef struct packed {
    logic [NUM_WE-1:0] we;
    logic [RSEL_W-1:0] rsel;
    logic              ctr_start;
    logic              ctr_stop;
    logic              opb_set;
    logic              opb_clr;
    logic [NUM_CH-1:0] pop;
  } dec_out_t;
endpackage

// File: rtl/regdec_strobe.sv
module regdec_strobe (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sel_i,
  output logic start_o
);
  logic sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_q <= 1'b0;
    else         sel_q <= sel_i;
  end

  assign start_o = sel_i & ~sel_q;
endmodule

// File: rtl/regdec_modeptr.sv
module regdec_modeptr (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mode_acc_i,
  input  logic rst_cmd_i,
  output logic ptr_o
);
  logic ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         ptr_q <= 1'b0;
    else if (rst_cmd_i)  ptr_q <= 1'b0;
    else if (mode_acc_i) ptr_q <= 1'b1;
  end

  assign ptr_o = ptr_q;

  // R3
  ptr_adv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_acc_i && !rst_cmd_i) |=> ptr_q);
  // R3
  ptr_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptr_q && !rst_cmd_i) |=> ptr_q);
  // R4
  ptr_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_cmd_i |=> !ptr_q);
endmodule

// File: rtl/regdec_decode.sv
module regdec_decode
  import regdec_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int CMD_LSB    = 4,
  parameter int CMD_W      = 3,
  parameter int CMD_RSTPTR = 1
) (
  input  logic              start_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [NUM_CH-1:0] ptr_i,
  output logic [NUM_CH-1:0] mode_acc_o,
  output logic [NUM_CH-1:0] rst_cmd_o,
  output dec_out_t          dec_o
);
  localparam int LOC_W = ADDR_W - 1;

  logic             ch;
  logic [LOC_W-1:0] loc;
  logic             cmd_is_rst;

  assign ch  = addr_i[ADDR_W-1];
  assign loc = addr_i[LOC_W-1:0];
  assign cmd_is_rst = (wdata_i[CMD_LSB +: CMD_W] == CMD_W'(CMD_RSTPTR));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign mode_acc_o[c] = start_i && (ch == c[0]) && (loc == '0);
    assign rst_cmd_o[c]  = start_i && wr_i && (ch == c[0]) &&
                           (loc == LOC_W'(2)) && cmd_is_rst;
  end

  always_comb begin
    int we_base;
    int rs_base;
    dec_o   = '0;
    we_base = ch ? WE_CH_STRIDE : 0;
    rs_base = ch ? RS_CH_STRIDE : 0;
    if (loc < LOC_W'(4)) begin
      unique case (loc[1:0])
        2'd0: if (wr_i) dec_o.we[we_base + WE_MR1 + int'(ptr_i[ch])] = 1'b1;
              else      dec_o.rsel = RSEL_W'(rs_base + int'(RS_MR1A) + int'(ptr_i[ch]));
        2'd1: if (wr_i) dec_o.we[we_base + WE_CSEL] = 1'b1;
              else      dec_o.rsel = RSEL_W'(rs_base + int'(RS_SRA));
        2'd2: if (wr_i) dec_o.we[we_base + WE_CMD] = 1'b1;
        2'd3: if (wr_i) dec_o.we[we_base + WE_THR] = 1'b1;
              else begin
                dec_o.rsel    = RSEL_W'(rs_base + int'(RS_RHRA));
                dec_o.pop[ch] = 1'b1;
              end
        default: ;
      endcase
    end else if (!ch) begin
      unique case (loc[1:0])
        2'd0: if (wr_i) dec_o.we[WE_AUX]  = 1'b1; else dec_o.rsel = RS_ICHG;
        2'd1: if (wr_i) dec_o.we[WE_IMSK] = 1'b1; else dec_o.rsel = RS_ISTAT;
        2'd2: if (wr_i) dec_o.we[WE_CTHI] = 1'b1; else dec_o.rsel = RS_CTHI;
        2'd3: if (wr_i) dec_o.we[WE_CTLO] = 1'b1; else dec_o.rsel = RS_CTLO;
        default: ;
      endcase
    end else begin
      unique case (loc[1:0])
        2'd0: if (wr_i) dec_o.we[WE_IVEC]  = 1'b1; else dec_o.rsel = RS_IVEC;
        2'd1: if (wr_i) dec_o.we[WE_OPCFG] = 1'b1; else dec_o.rsel = RS_IPORT;
        2'd2: if (wr_i) dec_o.opb_set = 1'b1; else dec_o.ctr_start = 1'b1;
        2'd3: if (wr_i) dec_o.opb_clr = 1'b1; else dec_o.ctr_stop  = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/regdec_top.sv
module regdec_top
  import regdec_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int CMD_LSB    = 4,
  parameter int CMD_W      = 3,
  parameter int CMD_RSTPTR = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [NUM_WE-1:0] we_o,
  output logic [RSEL_W-1:0] rd_sel_o,
  output logic              ctr_start_o,
  output logic              ctr_stop_o,
  output logic              opb_set_o,
  output logic              opb_clr_o,
  output logic [NUM_CH-1:0] rx_pop_o
);
  logic              start;
  logic [NUM_CH-1:0] ptr;
  logic [NUM_CH-1:0] mode_acc;
  logic [NUM_CH-1:0] rst_cmd;
  dec_out_t          dec;
  dec_out_t          out_q;

  regdec_strobe u_strobe (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sel_i   (sel_i),
    .start_o (start)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ptr
    regdec_modeptr u_ptr (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .mode_acc_i (mode_acc[c]),
      .rst_cmd_i  (rst_cmd[c]),
      .ptr_o      (ptr[c])
    );
  end

  regdec_decode #(
    .DATA_W     (DATA_W),
    .CMD_LSB    (CMD_LSB),
    .CMD_W      (CMD_W),
    .CMD_RSTPTR (CMD_RSTPTR)
  ) u_dec (
    .start_i    (start),
    .wr_i       (wr_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .ptr_i      (ptr),
    .mode_acc_o (mode_acc),
    .rst_cmd_o  (rst_cmd),
    .dec_o      (dec)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    out_q <= '0;
    else if (start) out_q <= dec;
    else            out_q <= '0;
  end

  assign we_o        = out_q.we;
  assign rd_sel_o    = out_q.rsel;
  assign ctr_start_o = out_q.ctr_start;
  assign ctr_stop_o  = out_q.ctr_stop;
  assign opb_set_o   = out_q.opb_set;
  assign opb_clr_o   = out_q.opb_clr;
  assign rx_pop_o    = out_q.pop;

  logic any_out;
  assign any_out = (|we_o) || (rd_sel_o != RS_NONE) || ctr_start_o || ctr_stop_o ||
                   opb_set_o || opb_clr_o || (|rx_pop_o);

  // R2
  single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_out |=> !any_out);
  // R2
  we_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(we_o));
  // R7
  action_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ctr_start_o, ctr_stop_o, opb_set_o, opb_clr_o}));
  // R9
  pop_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_pop_o != '0) |-> (rd_sel_o == RS_RHRA || rd_sel_o == RS_RHRB));
  // R10
  rw_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|we_o) |-> (rd_sel_o == RS_NONE));
endmodule

// File: tb/sim_regdec_top.sv
module sim_regdec_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sel_i = 1'b0;
  logic       wr_i = 1'b0;
  logic [3:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [15:0] we_o;
  logic [3:0]  rd_sel_o;
  logic        ctr_start_o, ctr_stop_o, opb_set_o, opb_clr_o;
  logic [1:0]  rx_pop_o;

  regdec_top u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(sel_i), .wr_i(wr_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .we_o(we_o), .rd_sel_o(rd_sel_o),
    .ctr_start_o(ctr_start_o), .ctr_stop_o(ctr_stop_o),
    .opb_set_o(opb_set_o), .opb_clr_o(opb_clr_o), .rx_pop_o(rx_pop_o)
  );

  always #5 clk_i = ~clk_i;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  bit mptr[2];

  logic [25:0] obs;
  assign obs = {we_o, rd_sel_o, ctr_start_o, ctr_stop_o, opb_set_o, opb_clr_o, rx_pop_o};

  function automatic logic [25:0] pk(int we_bit, int rs, logic [3:0] act, logic [1:0] pop);
    logic [15:0] we = '0;
    if (we_bit >= 0) we[we_bit] = 1'b1;
    return {we, 4'(rs), act, pop};
  endfunction

  function automatic logic [25:0] model(bit w, logic [3:0] a);
    case (a)
      4'h0: return w ? pk(mptr[0] ? 1 : 0, 0, 4'b0, 2'b0) : pk(-1, mptr[0] ? 2 : 1, 4'b0, 2'b0);
      4'h1: return w ? pk(2, 0, 4'b0, 2'b0)  : pk(-1, 3, 4'b0, 2'b0);
      4'h2: return w ? pk(3, 0, 4'b0, 2'b0)  : '0;
      4'h3: return w ? pk(4, 0, 4'b0, 2'b0)  : pk(-1, 4, 4'b0, 2'b01);
      4'h4: return w ? pk(5, 0, 4'b0, 2'b0)  : pk(-1, 5, 4'b0, 2'b0);
      4'h5: return w ? pk(6, 0, 4'b0, 2'b0)  : pk(-1, 6, 4'b0, 2'b0);
      4'h6: return w ? pk(7, 0, 4'b0, 2'b0)  : pk(-1, 7, 4'b0, 2'b0);
      4'h7: return w ? pk(8, 0, 4'b0, 2'b0)  : pk(-1, 8, 4'b0, 2'b0);
      4'h8: return w ? pk(mptr[1] ? 10 : 9, 0, 4'b0, 2'b0) : pk(-1, mptr[1] ? 10 : 9, 4'b0, 2'b0);
      4'h9: return w ? pk(11, 0, 4'b0, 2'b0) : pk(-1, 11, 4'b0, 2'b0);
      4'hA: return w ? pk(12, 0, 4'b0, 2'b0) : '0;
      4'hB: return w ? pk(13, 0, 4'b0, 2'b0) : pk(-1, 12, 4'b0, 2'b10);
      4'hC: return w ? pk(14, 0, 4'b0, 2'b0) : pk(-1, 13, 4'b0, 2'b0);
      4'hD: return w ? pk(15, 0, 4'b0, 2'b0) : pk(-1, 14, 4'b0, 2'b0);
      4'hE: return w ? pk(-1, 0, 4'b0010, 2'b0) : pk(-1, 0, 4'b1000, 2'b0);
      default: return w ? pk(-1, 0, 4'b0001, 2'b0) : pk(-1, 0, 4'b0100, 2'b0);
    endcase
  endfunction

  function automatic string tag_of(bit w, logic [3:0] a);
    case (a[2:0])
      3'd0: return (a[3] == 1'b0) ? "R3" : "R3_chB";
      3'd1: return "R5";
      3'd2: return "R6";
      3'd3: return w ? "R5" : "R9";
      default: return (a[3] && a[2:1] == 2'b11) ? "R7" : "R8";
    endcase
  endfunction

  task automatic check(string tag, logic [25:0] act, logic [25:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(bit w, logic [3:0] a, logic [7:0] d, int hold);
    logic [25:0] exp;
    @(negedge clk_i);
    sel_i = 1'b1; wr_i = w; addr_i = a; wdata_i = d;
    exp = model(w, a);
    if (a[2:0] == 3'd0) mptr[a[3]] = 1'b1;
    if (w && a[2:0] == 3'd2 && d[6:4] == 3'b001) mptr[a[3]] = 1'b0;
    @(negedge clk_i);
    check(tag_of(w, a), obs, exp);
    for (int i = 1; i < hold; i++) begin
      @(negedge clk_i);
      check("R2", obs, '0);
    end
    sel_i = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    mptr[0] = 1'b0; mptr[1] = 1'b0;
    repeat (3) @(negedge clk_i);
    check("R1", obs, '0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1", obs, '0);

    // R3: back-to-back mode reads, pointer advance vs decode
    access(1'b0, 4'h0, 8'h00, 1);
    access(1'b0, 4'h0, 8'h00, 1);
    access(1'b1, 4'h0, 8'h00, 1);
    // R4: reset A pointer, B still at MR1 until first access
    access(1'b1, 4'h2, 8'h10, 1);
    access(1'b1, 4'h0, 8'h00, 1);
    access(1'b1, 4'h8, 8'h00, 1);
    access(1'b1, 4'h2, 8'h10, 1);
    access(1'b0, 4'h8, 8'h00, 1);
    // R4: non-reset command leaves pointer
    access(1'b1, 4'hA, 8'h20, 1);
    access(1'b0, 4'h8, 8'h00, 1);
    // R6: reserved reads change nothing
    access(1'b1, 4'hA, 8'h10, 1);
    access(1'b0, 4'hA, 8'h00, 2);
    access(1'b0, 4'h2, 8'h00, 1);
    access(1'b0, 4'h8, 8'h00, 1);
    // R2: long strobe, R7 actions, R9 pops
    access(1'b0, 4'hE, 8'h00, 4);
    access(1'b0, 4'hF, 8'h00, 1);
    access(1'b1, 4'hE, 8'h00, 3);
    access(1'b1, 4'hF, 8'h00, 1);
    access(1'b0, 4'h3, 8'h00, 3);
    access(1'b0, 4'hB, 8'h00, 1);
    // R10: all addresses both directions
    for (int a = 0; a < 16; a++) begin
      access(1'b1, 4'(a), 8'h00, 1);
      access(1'b0, 4'(a), 8'h00, 1);
    end
    // R8 and the rest: random mix
    for (int k = 0; k < 400; k++) begin
      logic [3:0] a = 4'($urandom_range(0, 15));
      logic [7:0] d = 8'($urandom);
      if ($urandom_range(0, 3) == 0) d[6:4] = 3'b001;
      access(1'($urandom), a, d, int'($urandom_range(1, 3)));
    end
    @(negedge clk_i);
    check("R2", obs, '0);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule